// File: doc/BRIEF.md
# Infrared Pulse-Width Symbol Capture

This block receives a demodulated infrared line and records the length of each pulse pair. It waits for the line to fall. It counts how long the line stays low, then how long it stays high, and packs the two counts into one 32-bit symbol. Symbols are queued in a FIFO, and a host drains the FIFO through a small register bus that has separate write and read strobes. A programmable prescaler sets the length of one count unit. The prescaler value is the clock rate in MHz minus one, which gives a 1 MHz base tick, and ten base ticks make one unit (10 us).

A frame ends while the line rests high. When low plus high reaches a programmable maximum, the high count is clamped so that the sum equals the maximum. That symbol is stored, a timeout flag is raised, and the capture engine waits for the next falling edge. A receive flag rises when the number of stored symbols reaches a programmable threshold. An overflow flag rises when a symbol arrives while the FIFO is full. On overflow the stored entries are kept and the new symbol is dropped, so the host must drain the FIFO. An interrupt line is the OR of the flags that are not masked.

Register word addresses (3-bit `reg_addr`):

| Address | Register | Behaviour |
|---|---|---|
| 0 | enable | write bit0 to enable; read bit0 = enabled, bit1 = busy |
| 1 | config | read/write configuration word |
| 2 | start | write any value to begin capture |
| 3 | mask | bits 2:0, a 1 masks the matching flag |
| 4 | status | flags: receive 8/24, timeout 9/25, overflow 10/26 |
| 5 | clear | write 1s to clear flags |
| 6 | pop | read returns and removes the oldest symbol |
| 7 | level | read returns the number of stored symbols |

Configuration word layout:

| Bits | Field |
|---|---|
| 31:16 | maximum symbol width |
| 15:14 | format (stored only) |
| 13:8 | threshold minus one |
| 7 | raw flag (stored only) |
| 6:0 | prescaler |

Top module: `ir_rx_top`

## Requirements
- R1: After reset, the config word reads 0x3E80_0080 (maximum width 16000, raw flag set, threshold field 0, prescaler 0). The level register, the status register and `irq` all read 0.
- R2: Writing 1 to bit0 of the enable register sets the busy bit (enable read bit1) for BUSY_CYCLES clocks. A write to the start register starts capture only when the block is enabled and not busy. Otherwise the write is ignored and no symbol is stored.
- R3: A symbol word holds the low count in bits 15:0 and the high count in bits 31:16. A phase lasting D clocks between synchronized edges counts floor((D-1)/U) units, where U = 10*(prescaler+1).
- R4: After start, the engine stays idle until the first falling edge on the synchronized line. Earlier low phases and rising edges produce no symbol.
- R5: In the high phase, when low+high would reach the maximum width, a symbol with high = maximum - low is stored. The timeout flag is then set, and the engine returns to idle.
- R6: The receive flag is set when a stored symbol brings the FIFO count to at least the threshold field plus one. Below that count the flag stays clear.
- R7: A symbol that arrives while the FIFO holds FIFO_DEPTH entries is dropped and sets the overflow flag. The stored entries and the count are unchanged.
- R8: Reading the pop register while the FIFO is empty returns 0 and leaves the count at 0.
- R9: Reading the level register returns the current number of stored symbols.
- R10: Each flag appears at two status bit positions: receive at 8 and 24, timeout at 9 and 25, overflow at 10 and 26. `irq` is high when any flag whose mask bit is 0 is set.
- R11: Writing the clear register with bit16, bit17 or bit18 set clears the receive, timeout or overflow flag respectively. A low byte of 0xFF clears all flags.
- R12: Writing 0 to the enable register stops capture. Later line activity stores nothing until capture is started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe; data valid on the next cycle |
| reg_addr | input | 3 | register word address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, registered |
| ir_in | input | 1 | demodulated infrared line, idles high |
| irq | output | 1 | interrupt request, OR of unmasked flags |

## Verification
The hardest state to reach is a full FIFO with symbols still arriving. That needs more than FIFO_DEPTH complete low/high pairs, each paced by the prescaler, with no read in between. The bench sets a small prescaler and drives 66 short, identical symbols back to back. It then disables capture so that no timeout symbol interferes, and drains the retained entries one by one. The clamp case is reached by setting a small maximum width and leaving the line high after the last symbol.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    localparam int REG_AW = 3;
    localparam int PRESC_W = 7;

    localparam logic [REG_AW-1:0] A_ENABLE = 3'd0;
    localparam logic [REG_AW-1:0] A_CFG    = 3'd1;
    localparam logic [REG_AW-1:0] A_START  = 3'd2;
    localparam logic [REG_AW-1:0] A_MASK   = 3'd3;
    localparam logic [REG_AW-1:0] A_STATUS = 3'd4;
    localparam logic [REG_AW-1:0] A_CLEAR  = 3'd5;
    localparam logic [REG_AW-1:0] A_POP    = 3'd6;
    localparam logic [REG_AW-1:0] A_LEVEL  = 3'd7;

    localparam int F_RCV = 0;
    localparam int F_TMO = 1;
    localparam int F_OVF = 2;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_LOW  = 2'd1,
        CAP_HIGH = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic [15:0]        max_w;
        logic [1:0]         fmt;
        logic [5:0]         level;
        logic               raw;
        logic [PRESC_W-1:0] presc;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        max_w: 16'd16000,
        fmt:   2'd0,
        level: 6'd0,
        raw:   1'b1,
        presc: 7'd0
    };

endpackage

// File: rtl/ir_rx_edge.sv
module ir_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise,
    output logic fall
);
    // STAGES synchronizer flops followed by one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/ir_rx_timebase.sv
module ir_rx_timebase
    import ir_rx_pkg::*;
#(
    parameter int DECADE = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int DW = $clog2(DECADE);

    typedef struct packed {
        logic [PRESC_W-1:0] us;
        logic [DW-1:0]      dec;
    } tb_t;

    tb_t tb_d, tb_q;
    logic us_wrap, dec_last;

    always_comb begin
        tb_d     = tb_q;
        us_wrap  = (tb_q.us >= presc);
        dec_last = (tb_q.dec == DW'(DECADE - 1));
        tick     = us_wrap && dec_last;
        if (restart) begin
            tb_d = '0;
        end else if (us_wrap) begin
            tb_d.us  = '0;
            tb_d.dec = dec_last ? '0 : tb_q.dec + DW'(1);
        end else begin
            tb_d.us = tb_q.us + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (p_q.cnt == CW'(DEPTH));
    assign empty = (p_q.cnt == '0);
    assign count = p_q.cnt;
    assign head  = mem[p_q.rp];

    always_comb begin
        p_d     = p_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) p_d.wp = (p_q.wp == AW'(DEPTH - 1)) ? '0 : p_q.wp + AW'(1);
        if (do_pop)  p_d.rp = (p_q.rp == AW'(DEPTH - 1)) ? '0 : p_q.rp + AW'(1);
        p_d.cnt = p_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp] <= din;
    end
endmodule

// File: rtl/ir_rx_top.sv
module ir_rx_top
    import ir_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int BUSY_CYCLES = 8,
    parameter int DECADE      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ir_in,
    output logic              irq
);
    localparam int BW     = $clog2(BUSY_CYCLES + 1);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic          en;
        logic          run;
        logic [BW-1:0] busy;
        cfg_t          cfg;
        logic [2:0]    mask;
        logic [2:0]    flags;
        cap_state_e    cap;
        logic [15:0]   low;
        logic [15:0]   high;
        logic [31:0]   rdata;
    } st_t;

    st_t st_d, st_q;

    logic             edge_rise, edge_fall, unit_tick;
    logic [31:0]      fifo_head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full, fifo_empty;

    logic             sym_push, pop_req, push_ok;
    logic [31:0]      sym_data;
    logic [15:0]      clamp_w;
    logic [16:0]      sum_next;
    logic [CNT_W-1:0] cnt_after;
    logic [2:0]       flag_set, flag_clr;
    logic [31:0]      status_word;

    // signals observed by the bound checker
    logic busy_now, run_now, cap_idle;
    logic [2:0] flags_now;

    ir_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ir_in),
        .rise    (edge_rise),
        .fall    (edge_fall)
    );

    ir_rx_timebase #(.DECADE(DECADE)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (edge_rise | edge_fall),
        .presc   (st_q.cfg.presc),
        .tick    (unit_tick)
    );

    ir_rx_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sym_push),
        .din   (sym_data),
        .pop   (pop_req),
        .head  (fifo_head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign status_word = {5'b0, st_q.flags, 13'b0, st_q.flags, 8'b0};

    always_comb begin
        st_d      = st_q;
        sym_push  = 1'b0;
        sym_data  = '0;
        pop_req   = 1'b0;
        flag_set  = '0;
        flag_clr  = '0;
        clamp_w   = '0;
        sum_next  = 17'(st_q.low) + 17'(st_q.high) + 17'd1;

        if (st_q.busy != '0) st_d.busy = st_q.busy - BW'(1);

        // capture engine
        case (st_q.cap)
            CAP_IDLE: begin
                if (st_q.run && edge_fall) begin
                    st_d.cap = CAP_LOW;
                    st_d.low = '0;
                end
            end
            CAP_LOW: begin
                if (edge_rise) begin
                    st_d.cap  = CAP_HIGH;
                    st_d.high = '0;
                end else if (unit_tick && st_q.low != '1) begin
                    st_d.low = st_q.low + 16'd1;
                end
            end
            CAP_HIGH: begin
                if (edge_fall) begin
                    sym_push = 1'b1;
                    sym_data = {st_q.high, st_q.low};
                    st_d.cap = CAP_LOW;
                    st_d.low = '0;
                end else if (unit_tick) begin
                    if (sum_next >= 17'(st_q.cfg.max_w)) begin
                        clamp_w  = (st_q.cfg.max_w > st_q.low) ? st_q.cfg.max_w - st_q.low : '0;
                        sym_push = 1'b1;
                        sym_data = {clamp_w, st_q.low};
                        st_d.cap = CAP_IDLE;
                        flag_set[F_TMO] = 1'b1;
                    end else begin
                        st_d.high = st_q.high + 16'd1;
                    end
                end
            end
            default: st_d.cap = CAP_IDLE;
        endcase

        // register reads
        if (reg_rd) begin
            case (reg_addr)
                A_ENABLE: st_d.rdata = {30'b0, (st_q.busy != '0), st_q.en};
                A_CFG:    st_d.rdata = st_q.cfg;
                A_MASK:   st_d.rdata = {29'b0, st_q.mask};
                A_STATUS: st_d.rdata = status_word;
                A_POP: begin
                    pop_req    = !fifo_empty;
                    st_d.rdata = fifo_empty ? '0 : fifo_head;
                end
                A_LEVEL:  st_d.rdata = 32'(fifo_cnt);
                default:  st_d.rdata = '0;
            endcase
        end

        // flag sources
        push_ok   = sym_push && !fifo_full;
        cnt_after = fifo_cnt + CNT_W'(push_ok) - CNT_W'(pop_req);
        if (push_ok && (int'(cnt_after) >= int'(st_q.cfg.level) + 1)) flag_set[F_RCV] = 1'b1;
        if (sym_push && fifo_full) flag_set[F_OVF] = 1'b1;

        // register writes
        if (reg_wr) begin
            case (reg_addr)
                A_ENABLE: begin
                    st_d.en = reg_wdata[0];
                    if (reg_wdata[0]) begin
                        st_d.busy = BW'(BUSY_CYCLES);
                    end else begin
                        st_d.run = 1'b0;
                        st_d.cap = CAP_IDLE;
                    end
                end
                A_CFG:   st_d.cfg = cfg_t'(reg_wdata);
                A_START: if (st_q.en && st_q.busy == '0) st_d.run = 1'b1;
                A_MASK:  st_d.mask = reg_wdata[2:0];
                A_CLEAR: begin
                    flag_clr = {reg_wdata[18], reg_wdata[17], reg_wdata[16]};
                    if (reg_wdata[7:0] == 8'hFF) flag_clr = '1;
                end
                default: ;
            endcase
        end

        st_d.flags = (st_q.flags & ~flag_clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cfg   <= CFG_RESET;
            st_q.cap   <= CAP_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = |(st_q.flags & ~st_q.mask);

    assign busy_now  = (st_q.busy != '0);
    assign run_now   = st_q.run;
    assign cap_idle  = (st_q.cap == CAP_IDLE);
    assign flags_now = st_q.flags;
endmodule

// File: rtl/ir_rx_checker.sv
module ir_rx_checker
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic              clr_rcv_bit,
    input logic [31:0]       reg_rdata,
    input logic [CW-1:0]     fifo_cnt,
    input logic              fifo_full,
    input logic              sym_push,
    input logic              busy_now,
    input logic              run_now,
    input logic [2:0]        flags_now,
    input logic              cap_idle
);
    a_r2_start_blocked_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_START && busy_now && !run_now) |=> !run_now);

    a_r5_timeout_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_now[F_TMO]) |-> cap_idle);

    a_r7_full_push_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_push && fifo_full) |=> flags_now[F_OVF]);

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    a_r8_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_POP && fifo_cnt == '0) |=> (reg_rdata == 32'd0));

    a_r9_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_LEVEL) |=> (reg_rdata == 32'($past(fifo_cnt))));

    a_r11_clear_receive: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLEAR && clr_rcv_bit && !sym_push) |=> !flags_now[F_RCV]);
endmodule

bind ir_rx_top ir_rx_checker #(.DEPTH(FIFO_DEPTH)) u_ir_rx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .clr_rcv_bit (reg_wdata[16]),
    .reg_rdata   (reg_rdata),
    .fifo_cnt    (fifo_cnt),
    .fifo_full   (fifo_full),
    .sym_push    (sym_push),
    .busy_now    (busy_now),
    .run_now     (run_now),
    .flags_now   (flags_now),
    .cap_idle    (cap_idle)
);

// File: tb/ir_rx_top_bench.sv
module ir_rx_top_bench;
    import ir_rx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ir_in = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int NSYM = 10;

    always #5 clk = ~clk;

    ir_rx_top u_ir_rx_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ir_in     (ir_in),
        .irq       (irq)
    );

    function automatic logic [31:0] cfg_word(int maxw, int lvl, int ps);
        return {16'(maxw), 2'b00, 6'(lvl), 1'b1, 7'(ps)};
    endfunction

    function automatic logic [31:0] sym_word(int lo, int hi);
        return {16'(hi), 16'(lo)};
    endfunction

    function automatic int dur(int n, int u);
        return n * u + u / 2;
    endfunction

    function automatic logic [31:0] status_of(logic [2:0] f);
        return {5'b0, f, 13'b0, f, 8'b0};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic line(logic lv, int clks);
        @(negedge clk);
        ir_in = lv;
        repeat (clks - 1) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int lo [NSYM];
        int hi [NSYM];
        int bad;
        void'($urandom(32'd20240));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CFG, v);    chk("R1 config reset", v, 32'h3E80_0080);
        rd(A_LEVEL, v);  chk("R1 level reset", v, 32'd0);
        rd(A_STATUS, v); chk("R1 status reset", v, 32'd0);
        chk("R1 irq reset", {31'b0, irq}, 32'd0);

        // R2 start ignored before enable and while busy
        wr(A_START, 32'd1);
        line(0, 30); line(1, 30); line(0, 30); line(1, 30);
        wr(A_ENABLE, 32'd1);
        rd(A_ENABLE, v); chk("R2 busy after enable", v, 32'd3);
        wr(A_START, 32'd1);
        line(0, 30); line(1, 30); line(0, 30); line(1, 30);
        rd(A_LEVEL, v);  chk("R2 start while busy ignored", v, 32'd0);
        rd(A_ENABLE, v); chk("R2 busy expired", v, 32'd1);

        // R4 line already low at start: that low phase is not captured
        wr(A_CFG, cfg_word(60, 0, 0));
        line(0, 40);
        wr(A_START, 32'd1);
        line(0, 40);
        line(1, 25);
        for (int i = 0; i < NSYM; i++) begin
            lo[i] = int'($urandom_range(9, 1));
            hi[i] = int'($urandom_range(9, 1));
            line(0, dur(lo[i], 10));
            if (i < NSYM - 1) line(1, dur(hi[i], 10));
            else begin
                hi[i] = 60 - lo[i];
                line(1, 60 * 10 + 80);
            end
        end
        rd(A_LEVEL, v);  chk("R4 R9 symbols after first fall", v, 32'(NSYM));
        rd(A_STATUS, v); chk("R5 R10 receive and timeout mirrored", v, status_of(3'b011));
        chk("R10 irq unmasked", {31'b0, irq}, 32'd1);
        wr(A_MASK, 32'd7);
        chk("R10 irq masked", {31'b0, irq}, 32'd0);
        for (int i = 0; i < NSYM; i++) begin
            rd(A_POP, v);
            if (i < NSYM - 1) chk("R3 symbol word", v, sym_word(lo[i], hi[i]));
            else              chk("R5 clamped symbol", v, sym_word(lo[i], hi[i]));
        end
        wr(A_CLEAR, 32'h0001_0000);
        rd(A_STATUS, v); chk("R11 clear receive only", v, status_of(3'b010));
        wr(A_CLEAR, 32'h0000_00FF);
        rd(A_STATUS, v); chk("R11 clear all", v, 32'd0);
        rd(A_POP, v);    chk("R8 pop empty returns zero", v, 32'd0);
        rd(A_LEVEL, v);  chk("R8 count stays zero", v, 32'd0);
        wr(A_MASK, 32'd0);

        // R6 threshold of three symbols
        wr(A_CFG, cfg_word(60, 2, 0));
        line(0, 35); line(1, 35);
        line(0, 35); line(1, 35);
        line(0, 35);
        rd(A_STATUS, v); chk("R6 below threshold", v, 32'd0);
        line(1, 35);
        line(0, 35);
        rd(A_STATUS, v); chk("R6 threshold reached", v, status_of(3'b001));
        line(1, 700);
        wr(A_CLEAR, 32'h0000_00FF);
        rd(A_LEVEL, v);  chk("R9 level after threshold run", v, 32'd4);
        for (int i = 0; i < 4; i++) rd(A_POP, v);

        // R7 overflow with prescaler 1 (unit = 20 clocks)
        wr(A_CFG, cfg_word(60, 0, 1));
        for (int i = 0; i < 66; i++) begin
            line(0, dur(2, 20));
            line(1, dur(3, 20));
        end
        line(0, 30);
        wr(A_ENABLE, 32'd0);
        rd(A_LEVEL, v);  chk("R7 count held at depth", v, 32'd64);
        rd(A_STATUS, v); chk("R7 overflow flag", v, status_of(3'b101));
        rd(A_POP, v);    chk("R3 prescaled symbol", v, sym_word(2, 3));
        // R12 disabled: further activity stores nothing
        line(1, 50); line(0, 50); line(1, 50); line(0, 50); line(1, 1400);
        rd(A_LEVEL, v);  chk("R12 no capture while disabled", v, 32'd63);
        bad = 0;
        for (int i = 0; i < 63; i++) begin
            rd(A_POP, v);
            if (v !== sym_word(2, 3)) bad++;
        end
        chk("R7 retained entries intact", 32'(bad), 32'd0);
        rd(A_POP, v);    chk("R8 pop after drain", v, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule